// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core (nine-instruction subset)

This block is a small 32-bit processor that finishes every instruction in one clock. It supports register arithmetic (add, subtract, AND, OR, signed set-less-than), word loads and stores, branch-if-equal and an absolute jump. Each cycle it fetches a word from a local instruction array and decodes it. It reads two registers, computes in the ALU, and may touch a local data array. It commits at most one register write on the rising edge and picks the next program counter from three candidates.

Both memories are word arrays that belong to the block. The instruction array has no write port: simulation fills it through the hierarchy before reset is released. The only outputs are a trace port: the current program counter, and the register write that the present instruction will commit at the next edge.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0 and all 32 registers to 0. While reset is high, no register write is reported and no store takes place.
- R2: Register-format words (opcode field [31:26] = 0, shift field [10:6] = 0) write register [15:11] with the 32-bit wrapped result of the two source registers [25:21] and [20:16]. The function field [5:0] selects the operation: 32 = add, 34 = subtract, 36 = AND, 37 = OR.
- R3: Function code 42 writes 1 to the destination when the first source is less than the second as signed two's-complement numbers, and writes 0 otherwise.
- R4: Opcode 35 loads a word into register [20:16]. Opcode 43 stores register [20:16]. Both form the address as the first source plus the sign-extended 16-bit field [15:0]. The data array is indexed by address bits [DAW+1:2], so higher bits and bits [1:0] are dropped.
- R5: Opcode 4 compares the two source registers. When they are equal, the next PC is PC+4 plus the sign-extended 16-bit field shifted left by two, with the sum wrapping at 32 bits. Otherwise the next PC is PC+4.
- R6: Opcode 2 sets the next PC to bits [31:28] of PC+4, followed by field [25:0], followed by two zero bits.
- R7: Every other instruction advances the PC by 4. Instructions are fetched from index PC[IAW+1:2].
- R8: Register 0 always reads as zero, and a write addressed to it changes nothing.
- R9: Any other opcode, any other function code, or a nonzero shift field writes no register and stores nothing.
- R10: dbg_pc shows the current PC. dbg_wr_en/addr/data show the register write that commits at the next rising edge, and dbg_wr_en stays low for stores, branches, jumps and unsupported words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| dbg_pc | output | 32 | Program counter of the instruction now executing |
| dbg_wr_en | output | 1 | A register write commits at the next edge |
| dbg_wr_addr | output | 5 | Destination register of that write |
| dbg_wr_data | output | 32 | Value written |

## Verification
The hardest behaviour to reach from the ports is the part of the jump target that comes from the top nibble of PC+4. With small arrays a program never climbs that high on its own. The stimulus therefore takes a branch with the most negative offset, -32768 words, which wraps the PC into the 0xFFFE.... range. Because fetch aliases on the low index bits, execution continues at a known word. A following jump must then keep the 0xF prefix. A later backward branch and a self-jump check that the prefix survives. Index aliasing in the data array is covered by a store to address 0x7FFFFFFC, read back through address 252.

// File: rtl/sc_pkg.sv
`timescale 1ns/1ps
package sc_pkg;
  localparam int XW = 32;
  localparam int RAW = 5;

  localparam logic [5:0] OPC_REG  = 6'd0;
  localparam logic [5:0] OPC_LOAD = 6'd35;
  localparam logic [5:0] OPC_STOR = 6'd43;
  localparam logic [5:0] OPC_BEQ  = 6'd4;
  localparam logic [5:0] OPC_JMP  = 6'd2;

  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_AND = 6'd36;
  localparam logic [5:0] FN_OR  = 6'd37;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_op_e;

  typedef struct packed {
    logic    dst_rd;
    logic    b_imm;
    logic    wb_mem;
    logic    reg_wr;
    logic    mem_wr;
    logic    branch;
    logic    jump;
    alu_op_e alu_op;
  } ctl_t;

  function automatic logic [XW-1:0] sext16(input logic [15:0] imm);
    return {{(XW-16){imm[15]}}, imm};
  endfunction

  function automatic logic [XW-1:0] branch_dest(input logic [XW-1:0] pc4,
                                                input logic [15:0] imm);
    return pc4 + (sext16(imm) << 2);
  endfunction

  function automatic logic [XW-1:0] jump_dest(input logic [XW-1:0] pc4,
                                              input logic [25:0] tgt);
    return {pc4[XW-1:XW-4], tgt, 2'b00};
  endfunction
endpackage

// File: rtl/sc_regfile.sv
`timescale 1ns/1ps
module sc_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] regs_q [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we && (wa != '0)) begin
      regs_q[wa] <= wd;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs_q[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs_q[ra2];
endmodule

// File: rtl/sc_alu.sv
`timescale 1ns/1ps
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    unique case (op)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/sc_ctrl.sv
`timescale 1ns/1ps
module sc_ctrl
  import sc_pkg::*;
(
  input  logic [5:0] op,
  input  logic [5:0] funct,
  input  logic [4:0] shamt,
  output ctl_t       ctl
);
  always_comb begin
    ctl = '0;
    ctl.alu_op = ALU_ADD;
    unique case (op)
      OPC_REG: begin
        ctl.dst_rd = 1'b1;
        if (shamt == 5'd0) begin
          ctl.reg_wr = 1'b1;
          case (funct)
            FN_ADD:  ctl.alu_op = ALU_ADD;
            FN_SUB:  ctl.alu_op = ALU_SUB;
            FN_AND:  ctl.alu_op = ALU_AND;
            FN_OR:   ctl.alu_op = ALU_OR;
            FN_SLT:  ctl.alu_op = ALU_SLT;
            default: ctl.reg_wr = 1'b0;
          endcase
        end
      end
      OPC_LOAD: begin
        ctl.b_imm  = 1'b1;
        ctl.wb_mem = 1'b1;
        ctl.reg_wr = 1'b1;
      end
      OPC_STOR: begin
        ctl.b_imm  = 1'b1;
        ctl.mem_wr = 1'b1;
      end
      OPC_BEQ: begin
        ctl.branch = 1'b1;
        ctl.alu_op = ALU_SUB;
      end
      OPC_JMP: ctl.jump = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_core.sv
`timescale 1ns/1ps
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [XW-1:0] dbg_pc,
  output logic          dbg_wr_en,
  output logic [RAW-1:0] dbg_wr_addr,
  output logic [XW-1:0] dbg_wr_data
);
  logic [XW-1:0] imem_q [IMEM_WORDS];
  logic [XW-1:0] dmem_q [DMEM_WORDS];

  initial begin
    for (int i = 0; i < IMEM_WORDS; i++) imem_q[i] = '0;
    for (int i = 0; i < DMEM_WORDS; i++) dmem_q[i] = '0;
  end

  logic [XW-1:0]  pc_q, pc_plus4, br_dest, jmp_dest, pc_next;
  logic [XW-1:0]  ins, rd1, rd2, alu_b, alu_y, mem_rdata, wd;
  logic [RAW-1:0] wa;
  logic           alu_zero, br_taken, jmp_sel, wr_fire;
  ctl_t           ctl;

  // fetch
  assign ins = imem_q[pc_q[IAW+1:2]];

  sc_ctrl u_ctrl (
    .op    (ins[31:26]),
    .funct (ins[5:0]),
    .shamt (ins[10:6]),
    .ctl   (ctl)
  );

  assign wa      = ctl.dst_rd ? ins[15:11] : ins[20:16];
  assign wr_fire = ctl.reg_wr & ~rst;

  sc_regfile #(.NREG(32), .W(XW)) u_rf (
    .clk (clk),
    .rst (rst),
    .ra1 (ins[25:21]),
    .ra2 (ins[20:16]),
    .rd1 (rd1),
    .rd2 (rd2),
    .we  (wr_fire),
    .wa  (wa),
    .wd  (wd)
  );

  assign alu_b = ctl.b_imm ? sext16(ins[15:0]) : rd2;

  sc_alu #(.W(XW)) u_alu (
    .op   (ctl.alu_op),
    .a    (rd1),
    .b    (alu_b),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // data memory: word indexed, byte offset dropped
  assign mem_rdata = dmem_q[alu_y[DAW+1:2]];
  always_ff @(posedge clk) begin
    if (!rst && ctl.mem_wr) dmem_q[alu_y[DAW+1:2]] <= rd2;
  end

  assign wd = ctl.wb_mem ? mem_rdata : alu_y;

  // next-PC selection
  assign pc_plus4 = pc_q + 32'd4;
  assign br_dest  = branch_dest(pc_plus4, ins[15:0]);
  assign jmp_dest = jump_dest(pc_plus4, ins[25:0]);
  assign br_taken = ctl.branch & alu_zero;
  assign jmp_sel  = ctl.jump;
  assign pc_next  = jmp_sel ? jmp_dest : (br_taken ? br_dest : pc_plus4);

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  assign dbg_pc      = pc_q;
  assign dbg_wr_en   = wr_fire;
  assign dbg_wr_addr = wa;
  assign dbg_wr_data = wd;
endmodule

// File: rtl/sc_core_chk.sv
`timescale 1ns/1ps
module sc_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic [31:0] ins,
  input logic [31:0] rd1,
  input logic        jump,
  input logic        br_taken,
  input logic        wr_en,
  input logic [4:0]  wr_addr
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  // R1: one edge after reset the PC is zero
  always_ff @(posedge clk) begin
    if (rst_d) a_r1_reset_pc: assert (pc == 32'd0);
  end

  a_r7_sequential: assert property (@(posedge clk) disable iff (rst)
    (!jump && !br_taken) |=> (pc == $past(pc) + 32'd4));

  a_r5_branch_taken: assert property (@(posedge clk) disable iff (rst)
    (br_taken && !jump) |=> (pc == $past(pc) + 32'd4 +
      {{14{$past(ins[15])}}, $past(ins[15:0]), 2'b00}));

  a_r6_jump_target: assert property (@(posedge clk) disable iff (rst)
    jump |=> (pc == ((($past(pc) + 32'd4) & 32'hF000_0000) |
                     {4'd0, $past(ins[25:0]), 2'b00})));

  a_r8_zero_reg_read: assert property (@(posedge clk) disable iff (rst)
    (ins[25:21] == 5'd0) |-> (rd1 == 32'd0));

  a_r2_reg_dest: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ins[31:26] == 6'd0) |-> (wr_addr == ins[15:11]));
endmodule

bind sc_core sc_core_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .pc       (pc_q),
  .ins      (ins),
  .rd1      (rd1),
  .jump     (jmp_sel),
  .br_taken (br_taken),
  .wr_en    (dbg_wr_en),
  .wr_addr  (dbg_wr_addr)
);

// File: tb/sim_sc_core.sv
`timescale 1ns/1ps
module sim_sc_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] dbg_pc, dbg_wr_data;
  logic        dbg_wr_en;
  logic [4:0]  dbg_wr_addr;

  sc_core u0 (
    .clk(clk), .rst(rst), .dbg_pc(dbg_pc), .dbg_wr_en(dbg_wr_en),
    .dbg_wr_addr(dbg_wr_addr), .dbg_wr_data(dbg_wr_data)
  );

  always #10 clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] m_reg  [32];
  logic [31:0] m_dmem [64];
  logic [31:0] m_imem [64];
  logic [31:0] m_pc;
  string       pc_tag;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input int fn);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
  endfunction
  function automatic logic [31:0] enc_i(input int op, input int rs, input int rt, input logic [15:0] imm);
    return {op[5:0], rs[4:0], rt[4:0], imm};
  endfunction
  function automatic logic [31:0] enc_j(input int t);
    return {6'd2, t[25:0]};
  endfunction

  // behavioural reference: compare the cycle, then retire the instruction
  task automatic step_and_check();
    logic [31:0] w, a, b, addr, res, nxt;
    int op, fn, rs, rt, rd, sh;
    bit we;
    int wa;
    string wtag, ntag;
    w  = m_imem[(m_pc >> 2) % 64];
    op = int'(w[31:26]); rs = int'(w[25:21]); rt = int'(w[20:16]);
    rd = int'(w[15:11]); sh = int'(w[10:6]);  fn = int'(w[5:0]);
    a = m_reg[rs]; b = m_reg[rt];
    we = 0; wa = 0; res = 0; nxt = m_pc + 4; wtag = "R9"; ntag = "R7";
    if (op == 0) begin
      if (sh == 0) begin
        we = 1; wa = rd; wtag = "R2";
        case (fn)
          32: res = a + b;
          34: res = a - b;
          36: res = a & b;
          37: res = a | b;
          42: begin res = ($signed(a) < $signed(b)) ? 1 : 0; wtag = "R3"; end
          default: begin we = 0; wtag = "R9"; end
        endcase
      end
    end else if (op == 35) begin
      addr = a + {{16{w[15]}}, w[15:0]};
      we = 1; wa = rt; res = m_dmem[(addr >> 2) % 64]; wtag = "R4";
    end else if (op == 43) begin
      wtag = "R4";
    end else if (op == 4) begin
      ntag = "R5";
      if (a == b) nxt = m_pc + 4 + ({{16{w[15]}}, w[15:0]} << 2);
    end else if (op == 2) begin
      ntag = "R6";
      nxt = ((m_pc + 4) & 32'hF000_0000) | {4'd0, w[25:0], 2'b00};
    end
    if (we && wa == 0) wtag = "R8";

    chk(dbg_pc == m_pc, pc_tag, "pc", dbg_pc, m_pc);
    chk(dbg_wr_en == we, "R10", "wr_en", {31'd0, dbg_wr_en}, {31'd0, we});
    if (we) begin
      chk(dbg_wr_addr == wa[4:0], wtag, "wr_addr", {27'd0, dbg_wr_addr}, wa);
      chk(dbg_wr_data == res, wtag, "wr_data", dbg_wr_data, res);
    end

    if (op == 43) begin
      addr = a + {{16{w[15]}}, w[15:0]};
      m_dmem[(addr >> 2) % 64] = b;
    end
    if (we && wa != 0) m_reg[wa] = res;
    m_pc = nxt;
    pc_tag = ntag;
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) begin
      step_and_check();
      @(negedge clk);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 32; i++) m_reg[i] = '0;
    m_pc = '0;
    pc_tag = "R1";
  endtask

  initial begin
    logic [31:0] p [64];
    for (int i = 0; i < 64; i++) p[i] = enc_r(1, 1, 20, 32);
    p[0]  = enc_r(16, 0, 21, 37);            // reads r16: zero after reset (R1)
    p[1]  = enc_i(35, 0, 1, 16'd0);
    p[2]  = enc_i(35, 0, 2, 16'd4);
    p[3]  = enc_i(35, 0, 3, 16'd8);
    p[4]  = enc_i(35, 0, 4, 16'd12);
    p[5]  = enc_r(1, 2, 5, 32);
    p[6]  = enc_r(1, 2, 6, 34);
    p[7]  = enc_r(3, 2, 7, 36);
    p[8]  = enc_r(4, 1, 8, 37);
    p[9]  = enc_r(2, 1, 9, 42);              // R3: -3 < 5
    p[10] = enc_r(1, 2, 10, 42);             // R3: 5 < -3 false
    p[11] = enc_r(4, 3, 11, 42);             // R3: min < max
    p[12] = enc_r(3, 3, 3, 32) ^ enc_r(3, 3, 3, 32) ^ enc_r(3, 1, 3, 32); // R2: wrap
    p[13] = enc_r(1, 1, 0, 32);              // R8: write to r0
    p[14] = enc_r(0, 1, 12, 32);             // R8: r0 reads zero
    p[15] = enc_i(43, 1, 5, 16'd16);         // R4: unaligned addr 21
    p[16] = enc_i(35, 0, 13, 16'd20);
    p[17] = enc_i(43, 4, 6, 16'hFFFC);       // R4: addr 0x7FFFFFFC
    p[18] = enc_i(35, 0, 14, 16'd252);
    p[19] = enc_i(4, 1, 2, 16'd5);           // R5 not taken
    p[20] = enc_i(4, 12, 1, 16'd2);          // R5 taken forward
    p[21] = 32'hFC00_0000;
    p[23] = enc_r(1, 1, 15, 3);              // R9 bad funct
    p[24] = {6'd0, 5'd1, 5'd1, 5'd17, 5'd3, 6'd32}; // R9 shift field set
    p[25] = enc_i(4, 0, 0, 16'h8000);        // R5 wrap below zero
    p[26] = enc_r(13, 14, 15, 32);
    p[27] = enc_j(31);                       // R6 keeps 0xF prefix
    p[31] = enc_i(43, 0, 15, 16'd0);
    p[32] = enc_i(35, 0, 16, 16'd0);
    p[33] = enc_i(4, 19, 1, 16'd2);
    p[34] = enc_r(1, 0, 19, 32);
    p[35] = enc_i(4, 0, 0, 16'hFFFD);        // R5 backward
    p[36] = enc_i(8, 1, 22, 16'd7);          // R9 unknown opcode
    p[37] = enc_j(37);                       // R6 self loop
    #1;
    for (int i = 0; i < 64; i++) begin
      m_imem[i] = p[i];
      u0.imem_q[i] = p[i];
      m_dmem[i] = (i * 32'h0101_0101) ^ 32'h5A5A_0000;
    end
    m_dmem[0] = 32'd5;
    m_dmem[1] = 32'hFFFF_FFFD;
    m_dmem[2] = 32'h7FFF_FFFF;
    m_dmem[3] = 32'h8000_0000;
    for (int i = 0; i < 64; i++) u0.dmem_q[i] = m_dmem[i];

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(dbg_pc == 32'd0, "R1", "pc in reset", dbg_pc, 32'd0);
    chk(dbg_wr_en == 1'b0, "R1", "wr_en in reset", {31'd0, dbg_wr_en}, 32'd0);
    model_reset();
    rst = 1'b0;
    #1;
    run(48);

    // reset in the middle of a run: registers clear, data array kept
    rst = 1'b1;
    @(negedge clk);
    chk(dbg_pc == 32'd0, "R1", "pc after mid reset", dbg_pc, 32'd0);
    chk(dbg_wr_en == 1'b0, "R1", "wr_en in mid reset", {31'd0, dbg_wr_en}, 32'd0);
    model_reset();
    rst = 1'b0;
    #1;
    run(30);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #4_000_000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule